// File: doc/BRIEF.md
# BCD Calendar Counter with Access Freeze

This block keeps the time of day and the calendar date and advances them on a one-cycle 1 Hz strobe. Seconds, minutes, hours, day of month, weekday, month and two-digit year are presented to a host as BCD bytes in a 28-byte register space. The host reaches the space through a plain parallel port. It loads an address pointer, then reads or writes bytes. The pointer steps after every byte and wraps from the last register back to the first, so a whole block of registers can be moved in one burst.

While the host holds the burst line, or strobes a byte, the time counters do not move, so a multi-byte read is a coherent snapshot. One second tick that arrives during that window is remembered and applied in the first cycle after the window closes. Later ticks in the same window are lost. A halt bit stops counting so that the time can be set. A sticky flag in the seconds byte records that the oscillator was reported stopped.

Top module: `cal_keeper`

## Requirements
- R1: `ptr_load_i` loads the pointer from `ptr_i`, or loads 0 when `ptr_i` is 28 or more. In that cycle `rd_i` and `wr_i` are ignored. Otherwise each `rd_i` or `wr_i` cycle moves the pointer up by one, from 27 to 0. `rdata_o` shows the register at the pointer.
- R2: In any cycle where `burst_i`, `rd_i` or `wr_i` is high, a tick does not change the time registers (addresses 3 to 9).
- R3: A tick seen during a frozen cycle is held as one pending advance. It is applied in the first unfrozen cycle. Any further ticks in the same frozen window are dropped.
- R4: Time counts in BCD. Seconds and minutes run 00 to 59 and hours run 00 to 23, each carrying into the next. Weekday (address 7, bits 2:0, binary) runs 0 to 6 and steps with the day. Years run 00 to 99 and wrap.
- R5: Day (address 6) runs from 01 to the month length. Month (address 8) runs 01 to 12. February has 29 days when the year value is a multiple of 4, year 00 included, and 28 otherwise. April, June, September and November have 30 days and the other months have 31.
- R6: Bit 0 of the mode register (address 0) selects 12-hour format. In that format the hours byte holds PM in bit 5 and a BCD hour of 01 to 12 in bits 4:0, with midnight reading 12 AM and noon 12 PM. Hours writes are decoded in the format in force, and changing format keeps the time.
- R7: Bit 7 of the seconds byte is a stopped-oscillator flag. It is 1 after reset and is set in every cycle where `osc_stop_i` is high. It keeps its value until the host writes 0 to it.
- R8: While the halt bit (address 0, bit 1) is 1, ticks are ignored and a pending advance is discarded. Counting resumes with the first tick after the bit is cleared.
- R9: A host write to a time register takes effect in the next cycle and discards any pending advance.
- R10: Addresses 1, 2 and 10 to 27 read 0 and ignore writes. Unused bits of implemented registers read 0, and the mode register keeps only bits 1:0.
- R11: After reset the time is 00:00:00, day 01, weekday 0, month 01, year 00. The mode register is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle second strobe |
| osc_stop_i | input | 1 | Oscillator reported stopped |
| burst_i | input | 1 | Host burst in progress (freezes counting) |
| ptr_load_i | input | 1 | Load address pointer |
| ptr_i | input | 5 | Address to load |
| wr_i | input | 1 | Write byte at pointer, then step |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Byte read taken, step pointer |
| rdata_o | output | 8 | Register at pointer |
| ptr_o | output | 5 | Current pointer |

## Verification
Most wrong internal states reach the ports within one clock. A lost or doubled pending tick shows in the seconds byte on the first unfrozen cycle after a burst. A bad month-length or leap decision shows only when a tick lands on 23:59:59 of a month's last day. The bench therefore steps every day of a four-year cycle through that boundary and checks the whole date. A wrong 12/24-hour decode shows on the hours byte for particular hours, so all 24 hours are taken through both formats.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned NUM_REGS   = 28;
  localparam int unsigned ADDR_W     = $clog2(NUM_REGS);
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned TIME_BASE  = 3;
  localparam int unsigned SEL_W      = $clog2(NUM_FIELDS);

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_WDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] field_vec_t;

  function automatic byte_t to_bcd(byte_t v);
    byte_t t;
    t = v % 8'd100;
    return {4'(t / 8'd10), 4'(t % 8'd10)};
  endfunction

  function automatic byte_t from_bcd(byte_t b);
    return byte_t'({4'd0, b[7:4]}) * 8'd10 + byte_t'({4'd0, b[3:0]});
  endfunction

  function automatic byte_t month_len(byte_t mon, byte_t yr);
    case (mon)
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

  function automatic byte_t field_lo(int i);
    return (i == F_DAY || i == F_MON) ? 8'd1 : 8'd0;
  endfunction

  function automatic byte_t field_hi(int i, byte_t mon, byte_t yr);
    case (i)
      F_SEC, F_MIN: return 8'd59;
      F_HOUR:       return 8'd23;
      F_DAY:        return month_len(mon, yr);
      F_WDAY:       return 8'd6;
      F_MON:        return 8'd12;
      default:      return 8'd99;
    endcase
  endfunction
endpackage

// File: rtl/cal_tick_gate.sv
module cal_tick_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic freeze_i,
  input  logic halt_i,
  input  logic discard_i,
  output logic inc_o
);
  logic pending_q, pending_d;

  always_comb begin
    inc_o     = 1'b0;
    pending_d = pending_q;
    if (halt_i) begin
      pending_d = 1'b0;
    end else if (freeze_i) begin
      // newest tick survives a time write in the same cycle
      pending_d = tick_i | (pending_q & ~discard_i);
    end else begin
      inc_o     = pending_q | tick_i;
      pending_d = pending_q & tick_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= pending_d;

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i && tick_i && !halt_i |=> pending_q);
  a_r8_halt_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !pending_q);
endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
  import cal_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  byte_t            wr_val_i,
  output field_vec_t       time_o
);
  byte_t q [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] wrap, step;
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb
    for (int i = 0; i < NUM_FIELDS; i++)
      wrap[i] = (q[i] >= field_hi(i, q[F_MON], q[F_YEAR]));

  assign c_min  = inc_i & wrap[F_SEC];
  assign c_hour = c_min & wrap[F_MIN];
  assign c_day  = c_hour & wrap[F_HOUR];
  assign c_mon  = c_day & wrap[F_DAY];
  assign c_year = c_mon & wrap[F_MON];

  always_comb begin
    step         = '0;
    step[F_SEC]  = inc_i;
    step[F_MIN]  = c_min;
    step[F_HOUR] = c_hour;
    step[F_DAY]  = c_day;
    step[F_WDAY] = c_day;
    step[F_MON]  = c_mon;
    step[F_YEAR] = c_year;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                q[g] <= field_lo(g);
      else if (wr_i && wr_sel_i == SEL_W'(g))     q[g] <= wr_val_i;
      else if (step[g])                           q[g] <= wrap[g] ? field_lo(g) : q[g] + 8'd1;
    assign time_o[g] = q[g];
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !wr_i |=> $stable(time_o));
  a_r4_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i && q[F_SEC] < 8'd59 |=> q[F_SEC] == $past(q[F_SEC]) + 8'd1);
  a_r4_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i && q[F_SEC] == 8'd59 |=> q[F_SEC] == 8'd0 && q[F_MIN] != $past(q[F_MIN]));
  a_r5_leap_feb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i && q[F_SEC] == 8'd59 && q[F_MIN] == 8'd59 && q[F_HOUR] == 8'd23 &&
    q[F_MON] == 8'd2 && q[F_DAY] == 8'd28 && q[F_YEAR][1:0] == 2'b00 |=> q[F_DAY] == 8'd29);
endmodule

// File: rtl/cal_reg_port.sv
module cal_reg_port
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_load_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              wr_i,
  input  byte_t             wdata_i,
  input  logic              rd_i,
  input  logic              osc_stop_i,
  input  field_vec_t        time_i,
  output byte_t             rdata_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              halt_o,
  output logic              time_wr_o,
  output logic [SEL_W-1:0]  time_sel_o,
  output byte_t             time_val_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] TIME_LO   = ADDR_W'(TIME_BASE);
  localparam logic [ADDR_W-1:0] TIME_HI   = ADDR_W'(TIME_BASE + NUM_FIELDS - 1);
  localparam logic [ADDR_W-1:0] MODE_ADDR = '0;

  logic [ADDR_W-1:0] ptr_q;
  logic hour12_q, halt_q, osf_q;
  logic access, mode_wr, sec_wr;
  byte_t bcd [NUM_FIELDS];
  byte_t h12, h12_bcd, h12_in, h24_in;

  assign access    = (rd_i | wr_i) & ~ptr_load_i;
  assign time_wr_o = wr_i & ~ptr_load_i & (ptr_q >= TIME_LO) & (ptr_q <= TIME_HI);
  assign mode_wr   = wr_i & ~ptr_load_i & (ptr_q == MODE_ADDR);
  assign sec_wr    = time_wr_o & (time_sel_o == SEL_W'(F_SEC));
  assign time_sel_o = SEL_W'(ptr_q - TIME_LO);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         ptr_q <= '0;
    else if (ptr_load_i) ptr_q <= (ptr_i > LAST_ADDR) ? '0 : ptr_i;
    else if (access)     ptr_q <= (ptr_q == LAST_ADDR) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hour12_q <= 1'b0;
      halt_q   <= 1'b0;
    end else if (mode_wr) begin
      hour12_q <= wdata_i[0];
      halt_q   <= wdata_i[1];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     osf_q <= 1'b1;
    else if (sec_wr) osf_q <= wdata_i[7] | osc_stop_i;
    else             osf_q <= osf_q | osc_stop_i;

  // write decode: BCD byte to binary field value
  always_comb begin
    h12_in = from_bcd({3'b0, wdata_i[4:0]});
    h12_in = ((h12_in == 8'd12) ? 8'd0 : h12_in) + (wdata_i[5] ? 8'd12 : 8'd0);
    h24_in = from_bcd({2'b0, wdata_i[5:0]});
    case (int'(time_sel_o))
      F_SEC, F_MIN: time_val_o = from_bcd({1'b0, wdata_i[6:0]});
      F_HOUR:       time_val_o = hour12_q ? h12_in : h24_in;
      F_DAY:        time_val_o = from_bcd({2'b0, wdata_i[5:0]});
      F_WDAY:       time_val_o = {5'b0, wdata_i[2:0]};
      F_MON:        time_val_o = from_bcd({3'b0, wdata_i[4:0]});
      default:      time_val_o = from_bcd(wdata_i);
    endcase
  end

  // read path
  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) bcd[i] = to_bcd(time_i[i]);
    if (time_i[F_HOUR] == 8'd0)      h12 = 8'd12;
    else if (time_i[F_HOUR] > 8'd12) h12 = time_i[F_HOUR] - 8'd12;
    else                             h12 = time_i[F_HOUR];
    h12_bcd = to_bcd(h12);
  end

  always_comb begin
    rdata_o = '0;
    if (ptr_q == MODE_ADDR) rdata_o = {6'b0, halt_q, hour12_q};
    else if (ptr_q >= TIME_LO && ptr_q <= TIME_HI)
      case (int'(time_sel_o))
        F_SEC:   rdata_o = {osf_q, bcd[F_SEC][6:0]};
        F_MIN:   rdata_o = {1'b0, bcd[F_MIN][6:0]};
        F_HOUR:  rdata_o = hour12_q ? {2'b0, time_i[F_HOUR] >= 8'd12, h12_bcd[4:0]}
                                    : {2'b0, bcd[F_HOUR][5:0]};
        F_DAY:   rdata_o = {2'b0, bcd[F_DAY][5:0]};
        F_WDAY:  rdata_o = {5'b0, time_i[F_WDAY][2:0]};
        F_MON:   rdata_o = {3'b0, bcd[F_MON][4:0]};
        default: rdata_o = bcd[F_YEAR];
      endcase
  end

  assign ptr_o  = ptr_q;
  assign halt_o = halt_q;

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && !ptr_load_i && ptr_q == LAST_ADDR |=> ptr_q == '0);
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && !ptr_load_i && ptr_q < LAST_ADDR |=> ptr_q == $past(ptr_q) + 1'b1);
  a_r7_osf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_stop_i |=> osf_q);
  a_r10_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == 1 || ptr_q == 2 || ptr_q > TIME_HI) |-> rdata_o == '0);
endmodule

// File: rtl/cal_keeper.sv
module cal_keeper
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              osc_stop_i,
  input  logic              burst_i,
  input  logic              ptr_load_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] ptr_o
);
  logic freeze, halt, inc, time_wr;
  logic [SEL_W-1:0] time_sel;
  byte_t time_val;
  field_vec_t time_now;

  assign freeze = burst_i | wr_i | rd_i;

  cal_tick_gate i_gate (
    .clk_i, .rst_ni, .tick_i,
    .freeze_i (freeze),
    .halt_i   (halt),
    .discard_i(time_wr),
    .inc_o    (inc)
  );

  cal_time_counter i_count (
    .clk_i, .rst_ni,
    .inc_i   (inc),
    .wr_i    (time_wr),
    .wr_sel_i(time_sel),
    .wr_val_i(time_val),
    .time_o  (time_now)
  );

  cal_reg_port i_port (
    .clk_i, .rst_ni, .ptr_load_i, .ptr_i, .wr_i, .wdata_i, .rd_i, .osc_stop_i,
    .time_i    (time_now),
    .rdata_o, .ptr_o,
    .halt_o    (halt),
    .time_wr_o (time_wr),
    .time_sel_o(time_sel),
    .time_val_o(time_val)
  );

  a_r8_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt && !time_wr |=> $stable(time_now));
  a_r2_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze && !time_wr |=> $stable(time_now));
endmodule

// File: tb/test_cal_keeper.sv
module test_cal_keeper;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, osc_stop = 1'b0, burst = 1'b0;
  logic ptr_load = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [4:0] ptr_v = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] ptr_out;
  logic [7:0] got [7];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  cal_keeper i_cal_keeper (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .osc_stop_i(osc_stop),
    .burst_i(burst), .ptr_load_i(ptr_load), .ptr_i(ptr_v), .wr_i(wr),
    .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .ptr_o(ptr_out)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int bcd(int v);
    return (v / 10) * 16 + v % 10;
  endfunction

  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int enc12(int h);
    int h12;
    h12 = (h == 0) ? 12 : (h > 12 ? h - 12 : h);
    return (h >= 12 ? 32 : 0) + bcd(h12);
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask
  task automatic load(int a);
    ptr_load = 1'b1; ptr_v = 5'(a); cyc(); ptr_load = 1'b0;
  endtask
  task automatic wrb(int d);
    wr = 1'b1; wdata = 8'(d); cyc(); wr = 1'b0;
  endtask
  task automatic rdb(output logic [7:0] d);
    d = rdata; rd = 1'b1; cyc(); rd = 1'b0;
  endtask
  task automatic tick1();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask
  task automatic set_mode(int m);
    load(0); wrb(m);
  endtask
  task automatic set_time(int s, int mi, int h, int d, int w, int mo, int y);
    load(3); burst = 1'b1;
    wrb(bcd(s)); wrb(bcd(mi)); wrb(bcd(h)); wrb(bcd(d)); wrb(w); wrb(bcd(mo)); wrb(bcd(y));
    burst = 1'b0;
  endtask
  task automatic get_time();
    load(3); burst = 1'b1;
    for (int i = 0; i < 7; i++) rdb(got[i]);
    burst = 1'b0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int ed, em, ey, ew;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R11 reset state, R7 flag set at reset
    chk(ptr_out == 0, "R11 ptr", ptr_out, 0);
    chk(rdata == 8'h00, "R11 mode", rdata, 0);
    get_time();
    chk(got[0] == 8'h80, "R7 R11 seconds+flag", got[0], 8'h80);
    chk(got[1] == 0 && got[2] == 0, "R11 min/hour", {got[1], got[2]}, 0);
    chk(got[3] == 8'h01 && got[4] == 0, "R11 day/wday", {got[3], got[4]}, 16'h0100);
    chk(got[5] == 8'h01 && got[6] == 0, "R11 mon/year", {got[5], got[6]}, 16'h0100);

    // R1 pointer stepping and wrap
    load(26); chk(ptr_out == 26, "R1 load", ptr_out, 26);
    rdb(b);   chk(ptr_out == 27, "R1 step", ptr_out, 27);
    rdb(b);   chk(ptr_out == 0, "R1 wrap read", ptr_out, 0);
    load(27); wrb(8'h55); chk(ptr_out == 0, "R1 wrap write", ptr_out, 0);
    load(31); chk(ptr_out == 0, "R1 out of range load", ptr_out, 0);
    load(5); ptr_load = 1'b1; ptr_v = 5'd9; rd = 1'b1; cyc(); ptr_load = 1'b0; rd = 1'b0;
    chk(ptr_out == 9, "R1 load wins over read", ptr_out, 9);

    // R10 unimplemented space
    load(12); wrb(8'hFF); load(12);
    chk(rdata == 0, "R10 unused addr", rdata, 0);
    load(1); wrb(8'hFF); load(1);
    chk(rdata == 0, "R10 unused addr 1", rdata, 0);
    set_mode(8'hFF); load(0);
    chk(rdata == 8'h03, "R10 mode bits", rdata, 3);
    set_mode(0);
    load(7); wrb(8'hFD); load(7);
    chk(rdata == 8'h05, "R10 wday bits", rdata, 5);

    // R7 oscillator-stop flag
    load(3); wrb(8'h00); load(3);
    chk(rdata == 8'h00, "R7 cleared", rdata, 0);
    osc_stop = 1'b1; cyc(); osc_stop = 1'b0; cyc();
    chk(rdata[7] == 1'b1, "R7 set by input", rdata, 8'h80);
    cyc(); cyc();
    chk(rdata[7] == 1'b1, "R7 sticky", rdata, 8'h80);
    load(3); wrb(8'h00); load(3);
    chk(rdata == 8'h00, "R7 cleared again", rdata, 0);

    // R4 seconds sweep with minute carry
    set_time(0, 0, 0, 1, 0, 1, 0);
    load(3);
    for (int i = 0; i < 60; i++) begin
      tick1();
      chk(rdata == 8'(bcd((i + 1) % 60)), "R4 seconds", rdata, bcd((i + 1) % 60));
    end
    load(4);
    chk(rdata == 8'h01, "R4 minute carry", rdata, 1);

    // R4 R5 full rollover at end of century
    set_time(59, 59, 23, 31, 6, 12, 99);
    tick1(); get_time();
    chk(got[0] == 0 && got[1] == 0 && got[2] == 0, "R4 time wrap", {got[0], got[1], got[2]}, 0);
    chk(got[3] == 1 && got[4] == 0 && got[5] == 1 && got[6] == 0, "R4 R5 date wrap",
        {got[3], got[4], got[5], got[6]}, 32'h01000100);

    // R5 every day of a four-year cycle through midnight
    for (int y = 0; y < 4; y++)
      for (int m = 1; m <= 12; m++)
        for (int d = 1; d <= mlen(m, y); d++) begin
          set_time(59, 59, 23, d, d % 7, m, y);
          tick1(); get_time();
          ew = (d % 7 == 6) ? 0 : d % 7 + 1;
          ed = d + 1; em = m; ey = y;
          if (ed > mlen(m, y)) begin ed = 1; em = m + 1; end
          if (em > 12) begin em = 1; ey = y + 1; end
          chk(got[3] == 8'(bcd(ed)) && got[5] == 8'(bcd(em)) && got[6] == 8'(bcd(ey)) &&
              got[4] == 8'(ew) && got[0] == 0 && got[1] == 0 && got[2] == 0,
              "R5 day advance", {got[6], got[5], got[3], got[4]},
              {bcd(ey), bcd(em), bcd(ed), ew});
        end

    // R6 12-hour format, both directions, all hours
    for (int h = 0; h < 24; h++) begin
      set_mode(0); load(5); wrb(bcd(h));
      set_mode(1); load(5);
      chk(rdata == 8'(enc12(h)), "R6 read 12h", rdata, enc12(h));
      wrb(enc12(h));
      set_mode(0); load(5);
      chk(rdata == 8'(bcd(h)), "R6 write 12h", rdata, bcd(h));
    end
    set_mode(1);
    set_time(59, 59, 0, 5, 2, 3, 7);
    load(5); wrb(8'h31);
    tick1(); load(5);
    chk(rdata == 8'h12, "R6 11PM to 12AM", rdata, 8'h12);
    set_mode(0);

    // R2 R3 freeze holds one tick
    set_time(30, 20, 10, 5, 2, 3, 7);
    load(3); burst = 1'b1;
    tick1(); cyc();
    chk(rdata == 8'h30, "R2 frozen", rdata, 8'h30);
    tick1(); cyc();
    chk(rdata == 8'h30, "R2 frozen second tick", rdata, 8'h30);
    burst = 1'b0; cyc();
    chk(rdata == 8'h31, "R3 one pending applied", rdata, 8'h31);
    cyc(); cyc();
    chk(rdata == 8'h31, "R3 no extra advance", rdata, 8'h31);
    tick = 1'b1; rd = 1'b1; cyc(); tick = 1'b0; rd = 1'b0;
    load(3);
    chk(rdata == 8'h32, "R2 R3 strobe freeze then apply", rdata, 8'h32);

    // R8 halt
    set_mode(2); load(3);
    tick1(); cyc();
    chk(rdata == 8'h32, "R8 halted", rdata, 8'h32);
    set_mode(0); load(3); burst = 1'b1; tick1();
    load(0); wrb(2); burst = 1'b0; cyc(); cyc(); load(3);
    chk(rdata == 8'h32, "R8 pending dropped", rdata, 8'h32);
    set_mode(0); load(3); tick1();
    chk(rdata == 8'h33, "R8 resumes", rdata, 8'h33);

    // R9 write replaces pending tick
    load(3); burst = 1'b1; tick1(); wrb(8'h45); burst = 1'b0; cyc(); cyc();
    load(3);
    chk(rdata == 8'h45, "R9 write replaces pending", rdata, 8'h45);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule